// File: doc/BRIEF.md
# Programmable Loop Divider with Phase-Frequency Detector

This block sits in the feedback path of a digital frequency synthesizer. It takes the local-oscillator signal from one of two bands, each delivered as a single-cycle clock enable. The low band is prescaled by 8 and the high band by 64. A 14-bit programmable counter then divides the prescaled stream by N+1. The resulting feedback pulse is compared with a reference strobe in a two-flip-flop phase-frequency detector, which drives the source and sink controls of an external charge pump.

The pump sources current when the divided oscillator leads or runs faster than the reference. It sinks current when the oscillator lags or runs slower. The division value and the band select are double-buffered: a new value is copied into the working registers only at the terminal count of the counter, so a retune never produces a short or torn division cycle. The charge pump, the loop filter and the VCO are outside the block.

Top module: `loop_divider_pfd`

## Requirements
- R1: With band and N settled, `fb_pulse` is high for exactly one clock once every N+1 prescaled cycles, where N is the 14-bit unsigned value of `div_n`.
- R2: With the active band equal to 1 (high band), one prescaled cycle is 64 asserted `hi_tick` clocks, and `lo_tick` has no effect on any output.
- R3: With the active band equal to 0 (low band), one prescaled cycle is 8 asserted `lo_tick` clocks, and `hi_tick` has no effect on any output.
- R4: `div_n` and `band_hi` are sampled only in the clock where a terminal count occurs, and they govern the division that starts after that clock. After reset the working values are N = 0 and the low band.
- R5: With N = 0, a feedback pulse follows every prescaled cycle. With `lo_tick` held high in the low band, that is one pulse every 8 clocks.
- R6: `pump_src` rises the clock after a feedback pulse and stays high until the detector clears. A leading oscillator therefore asserts the source control.
- R7: `pump_snk` rises the clock after a reference strobe and stays high until the detector clears. A lagging oscillator therefore asserts the sink control.
- R8: When both pump controls are high, both fall on the next clock. A pulse or strobe that arrives in that clearing clock is kept and sets its own control again.
- R9: While reset is asserted, `fb_pulse`, `pump_src` and `pump_snk` are low.
- R10: If a feedback pulse and a reference strobe arrive in the same clock, both pump controls are high together for exactly one clock and then both are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_tick | input | 1 | Low-band oscillator clock enable |
| hi_tick | input | 1 | High-band oscillator clock enable |
| band_hi | input | 1 | Band request: 1 high band (/64), 0 low band (/8) |
| div_n | input | 14 | Requested division value N (divides by N+1) |
| ref_strobe | input | 1 | Single-cycle reference edge |
| fb_pulse | output | 1 | Divided oscillator pulse |
| pump_src | output | 1 | Charge pump source control |
| pump_snk | output | 1 | Charge pump sink control |

## Verification
Suppose the prescaler count or the programmable count drifts. Then the next `fb_pulse` arrives early or late, within one division period of the fault. A pump control that fails to rise then shows up in the very next clock. If the working band or N is loaded at the wrong moment, the pulse spacing of the division in progress changes. This shows within one prescaled cycle of the request. A detector that does not clear, or that drops an edge during clearing, leaves a pump control high or low one clock too long. The bench compares all three outputs against an independent model on every clock, so each of these faults is caught in the cycle it first shows at the ports.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  localparam int unsigned N_WIDTH  = 14;
  localparam int unsigned LO_RATIO = 8;
  localparam int unsigned HI_RATIO = 64;
endpackage

// File: rtl/lpd_prescaler.sv
module lpd_prescaler #(
  parameter int unsigned LO_RATIO = lpd_pkg::LO_RATIO,
  parameter int unsigned HI_RATIO = lpd_pkg::HI_RATIO
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_tick,
  input  logic hi_tick,
  input  logic band_act,
  output logic presc_tick
);
  localparam int unsigned MAXR = (LO_RATIO > HI_RATIO) ? LO_RATIO : HI_RATIO;
  localparam int unsigned CW   = (MAXR > 1) ? $clog2(MAXR) : 1;
  localparam logic [CW-1:0] LO_LAST = CW'(LO_RATIO - 1);
  localparam logic [CW-1:0] HI_LAST = CW'(HI_RATIO - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sel_tick;
  logic [CW-1:0] last;
  logic          wrap;

  always_comb begin
    sel_tick   = band_act ? hi_tick : lo_tick;
    last       = band_act ? HI_LAST : LO_LAST;
    wrap       = (cnt_q == last);
    presc_tick = sel_tick && wrap;
    cnt_d      = cnt_q;
    if (sel_tick) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (band_act ? HI_LAST : LO_LAST)); // R2
  AST_PRESC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_tick && !hi_tick) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/lpd_counter.sv
module lpd_counter #(
  parameter int unsigned NW = lpd_pkg::N_WIDTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          presc_tick,
  input  logic [NW-1:0] div_n,
  input  logic          band_req,
  output logic          band_act,
  output logic          fb_pulse
);
  logic [NW-1:0] cnt_q, cnt_d;
  logic [NW-1:0] n_q, n_d;
  logic          band_q, band_d;
  logic          term;

  always_comb begin
    term   = presc_tick && (cnt_q == n_q);
    cnt_d  = cnt_q;
    n_d    = n_q;
    band_d = band_q;
    if (presc_tick) begin
      if (term) begin
        cnt_d  = '0;
        n_d    = div_n;
        band_d = band_req;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      n_q      <= '0;
      band_q   <= 1'b0;
      fb_pulse <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      n_q      <= n_d;
      band_q   <= band_d;
      fb_pulse <= term;
    end
  end

  assign band_act = band_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= n_q); // R1
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse); // R1
  AST_N_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !term |=> ($stable(n_q) && $stable(band_q))); // R4
endmodule

// File: rtl/lpd_pfd.sv
module lpd_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_edge,
  input  logic ref_edge,
  output logic pump_src,
  output logic pump_snk
);
  logic src_q, src_d;
  logic snk_q, snk_d;
  logic clear;

  always_comb begin
    clear = src_q && snk_q;
    if (clear) begin
      src_d = fb_edge;
      snk_d = ref_edge;
    end else begin
      src_d = src_q || fb_edge;
      snk_d = snk_q || ref_edge;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      snk_q <= 1'b0;
    end else begin
      src_q <= src_d;
      snk_q <= snk_d;
    end
  end

  assign pump_src = src_q;
  assign pump_snk = snk_q;

  AST_SRC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_src) |-> $past(fb_edge)); // R6
  AST_SNK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_snk) |-> $past(ref_edge)); // R7
  AST_OVERLAP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_src && pump_snk && !(fb_edge && ref_edge)) |=> !(pump_src && pump_snk)); // R8
endmodule

// File: rtl/loop_divider_pfd.sv
module loop_divider_pfd #(
  parameter int unsigned NW       = lpd_pkg::N_WIDTH,
  parameter int unsigned LO_RATIO = lpd_pkg::LO_RATIO,
  parameter int unsigned HI_RATIO = lpd_pkg::HI_RATIO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_tick,
  input  logic          hi_tick,
  input  logic          band_hi,
  input  logic [NW-1:0] div_n,
  input  logic          ref_strobe,
  output logic          fb_pulse,
  output logic          pump_src,
  output logic          pump_snk
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       presc_tick;
  logic       band_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  lpd_prescaler #(.LO_RATIO(LO_RATIO), .HI_RATIO(HI_RATIO)) u_presc (
    .clk(clk), .rst_n(rst_core_n), .lo_tick(lo_tick), .hi_tick(hi_tick),
    .band_act(band_act), .presc_tick(presc_tick)
  );

  lpd_counter #(.NW(NW)) u_cnt (
    .clk(clk), .rst_n(rst_core_n), .presc_tick(presc_tick), .div_n(div_n),
    .band_req(band_hi), .band_act(band_act), .fb_pulse(fb_pulse)
  );

  lpd_pfd u_pfd (
    .clk(clk), .rst_n(rst_core_n), .fb_edge(fb_pulse), .ref_edge(ref_strobe),
    .pump_src(pump_src), .pump_snk(pump_snk)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_core_n |-> (!fb_pulse && !pump_src && !pump_snk)); // R9
endmodule

// File: tb/loop_divider_pfd_tb.sv
module loop_divider_pfd_tb;
  logic        clk;
  logic        rst_n;
  logic        lo_tick, hi_tick, band_hi, ref_strobe;
  logic [13:0] div_n;
  logic        fb_pulse, pump_src, pump_snk;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  bit    cmp_en = 0;
  string tag    = "R9";

  // behavioural model state
  int m_pc, m_cnt, m_n;
  bit m_band, m_pulse, m_src, m_snk;

  loop_divider_pfd u_dut (
    .clk(clk), .rst_n(rst_n), .lo_tick(lo_tick), .hi_tick(hi_tick),
    .band_hi(band_hi), .div_n(div_n), .ref_strobe(ref_strobe),
    .fb_pulse(fb_pulse), .pump_src(pump_src), .pump_snk(pump_snk)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_cnt = 0; m_n = 0; m_band = 0;
      m_pulse = 0; m_src = 0; m_snk = 0;
    end else begin
      bit tk, pt, term;
      int ratio;
      tk    = m_band ? hi_tick : lo_tick;
      ratio = m_band ? 64 : 8;
      pt    = tk && (m_pc == ratio - 1);
      if (tk) m_pc = (m_pc == ratio - 1) ? 0 : m_pc + 1;
      term  = pt && (m_cnt == m_n);
      if (m_src && m_snk) begin
        m_src = m_pulse; m_snk = ref_strobe;
      end else begin
        m_src = m_src | m_pulse; m_snk = m_snk | ref_strobe;
      end
      if (pt) begin
        if (term) begin m_cnt = 0; m_n = int'(div_n); m_band = band_hi; end
        else m_cnt++;
      end
      m_pulse = term;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      check(fb_pulse == m_pulse, {tag, " fb_pulse"}, fb_pulse, m_pulse);
      check(pump_src == m_src,   {tag, " pump_src"}, pump_src, m_src);
      check(pump_snk == m_snk,   {tag, " pump_snk"}, pump_snk, m_snk);
    end
  end

  task automatic cyc(input bit lo, input bit hi, input bit rs);
    @(negedge clk);
    lo_tick = lo; hi_tick = hi; ref_strobe = rs;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 0; lo_tick = 0; hi_tick = 0; band_hi = 0; ref_strobe = 0; div_n = '0;
    repeat (3) @(negedge clk);
    // R9: quiet outputs under reset
    check(!fb_pulse && !pump_src && !pump_snk, "R9 reset", {fb_pulse, pump_src, pump_snk}, 0);
    rst_n = 1;
    repeat (5) cyc(0, 0, 0);
    cmp_en = 1;

    // R1 R3 R4: low band, N=5, random high-band noise must be ignored
    tag = "R1 R3 R4"; div_n = 14'd5; band_hi = 0;
    for (int i = 0; i < 1500; i++) cyc($urandom_range(0, 1), $urandom_range(0, 1), 0);

    // R2 R4: request high band N=2 mid-division, low-band noise ignored
    tag = "R2 R4"; div_n = 14'd2; band_hi = 1;
    for (int i = 0; i < 4000; i++) cyc($urandom_range(0, 1), $urandom_range(0, 1), 0);

    // R5: N=0 back in low band, steady ticks
    tag = "R5"; div_n = 14'd0; band_hi = 0;
    for (int i = 0; i < 600; i++) cyc(1, 1, 0);
    begin
      int pulses = 0;
      for (int i = 0; i < 80; i++) begin
        cyc(1, 0, 0);
        if (fb_pulse) pulses++;
      end
      check(pulses == 10, "R5 pulse count", pulses, 10);
    end

    // R6: N=3, period 32 clocks, slow reference -> source dominates
    tag = "R6"; div_n = 14'd3;
    for (int i = 0; i < 640; i++) cyc(1, 0, (i % 64) == 63);
    // R7: fast reference -> sink dominates
    tag = "R7";
    for (int i = 0; i < 640; i++) cyc(1, 0, (i % 16) == 5);
    // R8: reference placed one clock after feedback lands in clearing cycle
    tag = "R8";
    for (int i = 0; i < 640; i++) cyc(1, 0, $urandom_range(0, 9) == 0);

    // R10: strobe aligned with feedback pulse
    tag = "R10";
    for (int k = 0; k < 4; k++) begin
      int guard = 0;
      while (!fb_pulse && guard < 200) begin cyc(1, 0, 0); guard++; end
      // fb_pulse is high in this clock; align the strobe with it
      lo_tick = 1; ref_strobe = 1;
      @(negedge clk); ref_strobe = 0;
      check(pump_src && pump_snk, "R10 overlap", {pump_src, pump_snk}, 3);
      @(negedge clk);
      check(!pump_src && !pump_snk, "R10 release", {pump_src, pump_snk}, 0);
    end

    cyc(0, 0, 0);
    cmp_en = 0;
    finish_run();
  end
endmodule